// File: doc/BRIEF.md
# SPI FIFO status and interrupt unit

This block sits between a register bus and a serial shift engine. It holds a transmit FIFO filled by bus writes to the data port and emptied by the shift engine. It also holds a receive FIFO filled by the shift engine and emptied by bus reads. Around the two queues it produces fill levels, a status word, sticky error flags, level-based threshold flags, a masked interrupt line and a pair of DMA request lines. The register decoder drives the one-cycle write strobes and the shared configuration data bus. It reads back the outputs.

Both threshold registers keep a write only when the value is below the FIFO depth. Software can therefore find the depth by writing rising values and stopping at the first one that does not read back. The error flags are sticky. A clear word can clear a chosen flag or all of them at once.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: After reset both levels are 0, the status word is 5'b01100, the raw interrupt word is 5'b00001, the masked word is 0, and the interrupt line and both DMA requests are low.
- R2: Each FIFO delivers words in push order. Each level output equals the number of stored entries and is updated at the clock edge that accepts a push or pop. A push in the same cycle as a pop on a full FIFO is accepted.
- R3: A bus write to a full transmit FIFO without an engine take in the same cycle is dropped. The level stays at DEPTH and raw bit 1 (transmit overflow) is set from the next cycle.
- R4: A bus read of an empty receive FIFO returns zero in that cycle and sets raw bit 2 (receive underflow) from the next cycle.
- R5: An engine put into a full receive FIFO without a bus read in the same cycle is dropped. The level stays at DEPTH and raw bit 3 (receive overflow) is set from the next cycle.
- R6: Raw bits 1 to 3 stay set until cleared. In a clear write, bit 1 clears receive underflow, bit 2 clears receive overflow, bit 3 clears transmit overflow and bit 0 clears all three. Any other flag is left untouched.
- R7: Raw bit 0 is 1 exactly while the transmit level is at or below the transmit threshold. Raw bit 4 is 1 exactly while the receive level is above the receive threshold. Neither is sticky.
- R8: A threshold write is stored only if its value is below DEPTH. Otherwise the register keeps its previous value.
- R9: The masked word equals the raw word ANDed with the 5-bit mask register, which resets to 0. The interrupt line is the OR of the masked word.
- R10: The status word bits are: bit 0 busy (engine busy input or transmit FIFO not empty), bit 1 transmit full, bit 2 transmit empty, bit 3 receive empty, bit 4 receive full.
- R11: In the DMA enable register, bit 0 enables receive requests and bit 1 enables transmit requests. The transmit request is high while enabled and the transmit level is at or below the transmit watermark. The receive request is high while enabled and the receive level is above the receive watermark.
- R12: When an overflow or underflow event and a clear of the same flag occur in one cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_tx_wr | input | 1 | Bus write to the transmit data port |
| bus_tx_wdata | input | DW | Word written to the transmit FIFO |
| bus_rx_rd | input | 1 | Bus read of the receive data port |
| bus_rx_rdata | output | DW | Head of the receive FIFO, zero when empty |
| eng_tx_take | input | 1 | Shift engine takes the transmit head |
| eng_tx_word | output | DW | Transmit head word |
| eng_tx_valid | output | 1 | Transmit FIFO holds at least one word |
| eng_rx_put | input | 1 | Shift engine delivers a received word |
| eng_rx_word | input | DW | Received word |
| eng_busy | input | 1 | Shift engine is mid-transfer |
| tx_thr_we | input | 1 | Write strobe, transmit threshold |
| rx_thr_we | input | 1 | Write strobe, receive threshold |
| tx_wm_we | input | 1 | Write strobe, transmit DMA watermark |
| rx_wm_we | input | 1 | Write strobe, receive DMA watermark |
| cfg_wdata | input | CFG_W | Shared data for the four strobes above |
| tx_thr | output | CFG_W | Transmit threshold readback |
| rx_thr | output | CFG_W | Receive threshold readback |
| mask_we | input | 1 | Write strobe, interrupt mask |
| mask_wdata | input | 5 | Interrupt mask value |
| clr_we | input | 1 | Write strobe, interrupt clear |
| clr_wdata | input | 4 | Clear bits |
| dma_en_we | input | 1 | Write strobe, DMA enables |
| dma_en_wdata | input | 2 | DMA enable bits |
| tx_level | output | LW | Transmit entries |
| rx_level | output | LW | Receive entries |
| status | output | 5 | Status word |
| raw_irq | output | 5 | Raw interrupt word |
| masked_irq | output | 5 | Masked interrupt word |
| irq | output | 1 | Interrupt line |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
Levels, status bits, threshold flags and DMA requests come from registered state through logic only. They are due right after the clock edge that accepts the push, pop or configuration write. The sticky flags are set or cleared on the edge that samples the event, so they also show one edge after the stimulus. The receive read data is combinational and is valid in the same cycle as the read strobe. The bench drives inputs on the falling edge and samples results a quarter period later or just after the following falling edge. Every check therefore lands after exactly one rising edge, with no race against it.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
    localparam int IRQ_N = 5;
    localparam int IRQ_TX_LOW  = 0;
    localparam int IRQ_TX_OVF  = 1;
    localparam int IRQ_RX_UDF  = 2;
    localparam int IRQ_RX_OVF  = 3;
    localparam int IRQ_RX_HIGH = 4;

    localparam int ST_N        = 5;
    localparam int ST_BUSY     = 0;
    localparam int ST_TX_FULL  = 1;
    localparam int ST_TX_EMPTY = 2;
    localparam int ST_RX_EMPTY = 3;
    localparam int ST_RX_FULL  = 4;

    localparam int CLR_N      = 4;
    localparam int CLR_ALL    = 0;
    localparam int CLR_RX_UDF = 1;
    localparam int CLR_RX_OVF = 2;
    localparam int CLR_TX_OVF = 3;

    localparam int DMA_RX_EN = 0;
    localparam int DMA_TX_EN = 1;

    typedef struct packed {
        logic tx_ovf;
        logic rx_udf;
        logic rx_ovf;
    } sticky_t;
endpackage

// File: rtl/sfu_fifo.sv
module sfu_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty,
    output logic          push_drop,
    output logic          pop_empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [LW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t      st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full    = (st_q.cnt == LW'(DEPTH));
        empty   = (st_q.cnt == '0);
        do_pop  = pop && !empty;
        do_push = push && (!full || do_pop);
        st_d    = st_q;
        if (do_push) st_d.wr = ptr_inc(st_q.wr);
        if (do_pop)  st_d.rd = ptr_inc(st_q.rd);
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr] <= wdata;
    end

    assign rdata     = empty ? '0 : mem_q[st_q.rd];
    assign level     = st_q.cnt;
    assign push_drop = push && !do_push;
    assign pop_empty = pop && empty;
endmodule

// File: rtl/sfu_cfg_reg.sv
module sfu_cfg_reg #(
    parameter int W           = 8,
    parameter int LIMIT       = 8,
    parameter bit CHECK_RANGE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] value
);
    logic [W-1:0] val_d, val_q;
    logic         accept;

    generate
        if (CHECK_RANGE) begin : g_range
            assign accept = (32'(wdata) < 32'(LIMIT));
        end else begin : g_free
            assign accept = 1'b1;
        end
    endgenerate

    always_comb begin
        val_d = val_q;
        if (we && accept) val_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign value = val_q;
endmodule

// File: rtl/sfu_irq_ctrl.sv
module sfu_irq_ctrl
    import sfu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_ovf_ev,
    input  logic             rx_udf_ev,
    input  logic             rx_ovf_ev,
    input  logic             tx_low,
    input  logic             rx_high,
    input  logic             clr_we,
    input  logic [CLR_N-1:0] clr_bits,
    input  logic             mask_we,
    input  logic [IRQ_N-1:0] mask_wdata,
    output logic [IRQ_N-1:0] raw,
    output logic [IRQ_N-1:0] masked,
    output logic             irq
);
    typedef struct packed {
        logic [IRQ_N-1:0] mask;
        sticky_t          sticky;
    } irq_st_t;

    irq_st_t st_d, st_q;
    sticky_t clr_sel;

    always_comb begin
        clr_sel.tx_ovf = clr_we && (clr_bits[CLR_ALL] || clr_bits[CLR_TX_OVF]);
        clr_sel.rx_udf = clr_we && (clr_bits[CLR_ALL] || clr_bits[CLR_RX_UDF]);
        clr_sel.rx_ovf = clr_we && (clr_bits[CLR_ALL] || clr_bits[CLR_RX_OVF]);

        st_d = st_q;
        st_d.sticky.tx_ovf = (st_q.sticky.tx_ovf && !clr_sel.tx_ovf) || tx_ovf_ev;
        st_d.sticky.rx_udf = (st_q.sticky.rx_udf && !clr_sel.rx_udf) || rx_udf_ev;
        st_d.sticky.rx_ovf = (st_q.sticky.rx_ovf && !clr_sel.rx_ovf) || rx_ovf_ev;
        if (mask_we) st_d.mask = mask_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        raw              = '0;
        raw[IRQ_TX_LOW]  = tx_low;
        raw[IRQ_TX_OVF]  = st_q.sticky.tx_ovf;
        raw[IRQ_RX_UDF]  = st_q.sticky.rx_udf;
        raw[IRQ_RX_OVF]  = st_q.sticky.rx_ovf;
        raw[IRQ_RX_HIGH] = rx_high;
        masked           = raw & st_q.mask;
        irq              = |masked;
    end
endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
    import sfu_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    parameter int CFG_W = 8,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_tx_wr,
    input  logic [DW-1:0]    bus_tx_wdata,
    input  logic             bus_rx_rd,
    output logic [DW-1:0]    bus_rx_rdata,
    input  logic             eng_tx_take,
    output logic [DW-1:0]    eng_tx_word,
    output logic             eng_tx_valid,
    input  logic             eng_rx_put,
    input  logic [DW-1:0]    eng_rx_word,
    input  logic             eng_busy,
    input  logic             tx_thr_we,
    input  logic             rx_thr_we,
    input  logic             tx_wm_we,
    input  logic             rx_wm_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] tx_thr,
    output logic [CFG_W-1:0] rx_thr,
    input  logic             mask_we,
    input  logic [4:0]       mask_wdata,
    input  logic             clr_we,
    input  logic [3:0]       clr_wdata,
    input  logic             dma_en_we,
    input  logic [1:0]       dma_en_wdata,
    output logic [LW-1:0]    tx_level,
    output logic [LW-1:0]    rx_level,
    output logic [4:0]       status,
    output logic [4:0]       raw_irq,
    output logic [4:0]       masked_irq,
    output logic             irq,
    output logic             tx_dma_req,
    output logic             rx_dma_req
);
    typedef struct packed {
        logic [1:0] dma_en;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic             tx_drop, tx_pop_empty, rx_drop, rx_pop_empty;
    logic [CFG_W-1:0] tx_wm, rx_wm;
    logic             tx_low, rx_high;

    sfu_fifo #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(bus_tx_wr), .wdata(bus_tx_wdata),
        .pop(eng_tx_take), .rdata(eng_tx_word),
        .level(tx_level), .full(tx_full), .empty(tx_empty),
        .push_drop(tx_drop), .pop_empty(tx_pop_empty)
    );

    sfu_fifo #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(eng_rx_put), .wdata(eng_rx_word),
        .pop(bus_rx_rd), .rdata(bus_rx_rdata),
        .level(rx_level), .full(rx_full), .empty(rx_empty),
        .push_drop(rx_drop), .pop_empty(rx_pop_empty)
    );

    // Interrupt thresholds clamp to the FIFO depth; DMA watermarks do not.
    sfu_cfg_reg #(.W(CFG_W), .LIMIT(DEPTH), .CHECK_RANGE(1'b1)) u_tx_thr (
        .clk(clk), .rst_n(rst_n), .we(tx_thr_we), .wdata(cfg_wdata), .value(tx_thr)
    );
    sfu_cfg_reg #(.W(CFG_W), .LIMIT(DEPTH), .CHECK_RANGE(1'b1)) u_rx_thr (
        .clk(clk), .rst_n(rst_n), .we(rx_thr_we), .wdata(cfg_wdata), .value(rx_thr)
    );
    sfu_cfg_reg #(.W(CFG_W), .LIMIT(DEPTH), .CHECK_RANGE(1'b0)) u_tx_wm (
        .clk(clk), .rst_n(rst_n), .we(tx_wm_we), .wdata(cfg_wdata), .value(tx_wm)
    );
    sfu_cfg_reg #(.W(CFG_W), .LIMIT(DEPTH), .CHECK_RANGE(1'b0)) u_rx_wm (
        .clk(clk), .rst_n(rst_n), .we(rx_wm_we), .wdata(cfg_wdata), .value(rx_wm)
    );

    assign tx_low  = (CFG_W'(tx_level) <= tx_thr);
    assign rx_high = (CFG_W'(rx_level) >  rx_thr);

    sfu_irq_ctrl u_irq (
        .clk(clk), .rst_n(rst_n),
        .tx_ovf_ev(tx_drop), .rx_udf_ev(rx_pop_empty), .rx_ovf_ev(rx_drop),
        .tx_low(tx_low), .rx_high(rx_high),
        .clr_we(clr_we), .clr_bits(clr_wdata),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .raw(raw_irq), .masked(masked_irq), .irq(irq)
    );

    always_comb begin
        st_d = st_q;
        if (dma_en_we) st_d.dma_en = dma_en_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status              = '0;
        status[ST_BUSY]     = eng_busy || !tx_empty;
        status[ST_TX_FULL]  = tx_full;
        status[ST_TX_EMPTY] = tx_empty;
        status[ST_RX_EMPTY] = rx_empty;
        status[ST_RX_FULL]  = rx_full;
        tx_dma_req = st_q.dma_en[DMA_TX_EN] && (CFG_W'(tx_level) <= tx_wm);
        rx_dma_req = st_q.dma_en[DMA_RX_EN] && (CFG_W'(rx_level) >  rx_wm);
    end

    assign eng_tx_valid = !tx_empty;
endmodule

// File: rtl/sfu_checker.sv
module sfu_checker #(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    parameter int CFG_W = 8,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_tx_wr,
    input logic             eng_tx_take,
    input logic             bus_rx_rd,
    input logic             eng_rx_put,
    input logic             clr_we,
    input logic [DW-1:0]    bus_rx_rdata,
    input logic [CFG_W-1:0] tx_thr,
    input logic [CFG_W-1:0] rx_thr,
    input logic [LW-1:0]    tx_level,
    input logic [LW-1:0]    rx_level,
    input logic [4:0]       status,
    input logic [4:0]       raw_irq,
    input logic [4:0]       masked_irq,
    input logic             irq
);
    assert_tx_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= LW'(DEPTH));

    assert_tx_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_tx_wr && !eng_tx_take && tx_level == LW'(DEPTH))
        |=> (raw_irq[1] && tx_level == LW'(DEPTH)));

    assert_rx_under_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rx_rd && rx_level == '0) |-> (bus_rx_rdata == '0));

    assert_rx_under_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rx_rd && rx_level == '0) |=> raw_irq[2]);

    assert_rx_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_put && !bus_rx_rd && rx_level == LW'(DEPTH))
        |=> (raw_irq[3] && rx_level == LW'(DEPTH)));

    assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_irq[1] && !clr_we) |=> raw_irq[1]);

    assert_thr_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(tx_thr) < 32'(DEPTH)) && (32'(rx_thr) < 32'(DEPTH)));

    assert_mask_subset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((masked_irq & ~raw_irq) == 5'b0) && (irq == (masked_irq != 5'b0)));

    assert_status_consistent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[1] && status[2]) && (status[2] == (tx_level == '0))
        && (status[3] == (rx_level == '0)));
endmodule

bind spi_fifo_irq_unit sfu_checker #(
    .DW(DW), .DEPTH(DEPTH), .CFG_W(CFG_W), .LW(LW)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .bus_tx_wr(bus_tx_wr), .eng_tx_take(eng_tx_take),
    .bus_rx_rd(bus_rx_rd), .eng_rx_put(eng_rx_put), .clr_we(clr_we),
    .bus_rx_rdata(bus_rx_rdata), .tx_thr(tx_thr), .rx_thr(rx_thr),
    .tx_level(tx_level), .rx_level(rx_level), .status(status),
    .raw_irq(raw_irq), .masked_irq(masked_irq), .irq(irq)
);

// File: tb/sim_spi_fifo_irq_unit.sv
module sim_spi_fifo_irq_unit;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int DEPTH = 8;
    localparam int CFG_W = 8;
    localparam int LW = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_tx_wr = 1'b0, bus_rx_rd = 1'b0, eng_tx_take = 1'b0, eng_rx_put = 1'b0, eng_busy = 1'b0;
    logic [DW-1:0] bus_tx_wdata = '0, eng_rx_word = '0;
    logic tx_thr_we = 1'b0, rx_thr_we = 1'b0, tx_wm_we = 1'b0, rx_wm_we = 1'b0;
    logic mask_we = 1'b0, clr_we = 1'b0, dma_en_we = 1'b0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic [4:0] mask_wdata = '0;
    logic [3:0] clr_wdata = '0;
    logic [1:0] dma_en_wdata = '0;
    logic [DW-1:0] bus_rx_rdata, eng_tx_word;
    logic eng_tx_valid, irq, tx_dma_req, rx_dma_req;
    logic [CFG_W-1:0] tx_thr, rx_thr;
    logic [LW-1:0] tx_level, rx_level;
    logic [4:0] status, raw_irq, masked_irq;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] tx_q[$];
    logic [DW-1:0] rx_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_fifo_irq_unit #(.DW(DW), .DEPTH(DEPTH), .CFG_W(CFG_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .bus_tx_wr(bus_tx_wr), .bus_tx_wdata(bus_tx_wdata),
        .bus_rx_rd(bus_rx_rd), .bus_rx_rdata(bus_rx_rdata),
        .eng_tx_take(eng_tx_take), .eng_tx_word(eng_tx_word), .eng_tx_valid(eng_tx_valid),
        .eng_rx_put(eng_rx_put), .eng_rx_word(eng_rx_word), .eng_busy(eng_busy),
        .tx_thr_we(tx_thr_we), .rx_thr_we(rx_thr_we), .tx_wm_we(tx_wm_we), .rx_wm_we(rx_wm_we),
        .cfg_wdata(cfg_wdata), .tx_thr(tx_thr), .rx_thr(rx_thr),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .clr_we(clr_we), .clr_wdata(clr_wdata),
        .dma_en_we(dma_en_we), .dma_en_wdata(dma_en_wdata),
        .tx_level(tx_level), .rx_level(rx_level), .status(status),
        .raw_irq(raw_irq), .masked_irq(masked_irq), .irq(irq),
        .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Monitor: compares words as the design hands them out.
    always @(negedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n && eng_tx_take && eng_tx_valid) begin
            if (tx_q.size() == 0) chk("R2 tx unexpected word", 32'(eng_tx_word), 32'hDEAD);
            else chk("R2 tx order", 32'(eng_tx_word), 32'(tx_q.pop_front()));
        end
        if (rst_n && bus_rx_rd) begin
            if (rx_q.size() == 0) chk("R2 rx unexpected read", 32'(bus_rx_rdata), 32'hDEAD);
            else chk("R2/R4 rx data", 32'(bus_rx_rdata), 32'(rx_q.pop_front()));
        end
    end

    task automatic tx_write(input logic [DW-1:0] w);
        @(negedge clk);
        if (int'(tx_level) < DEPTH) tx_q.push_back(w);
        bus_tx_wr = 1'b1; bus_tx_wdata = w;
        @(negedge clk);
        bus_tx_wr = 1'b0; #1;
    endtask

    task automatic tx_drain(input int n);
        @(negedge clk);
        eng_tx_take = 1'b1;
        repeat (n) @(negedge clk);
        eng_tx_take = 1'b0; #1;
    endtask

    task automatic rx_put(input logic [DW-1:0] w);
        @(negedge clk);
        if (int'(rx_level) < DEPTH) rx_q.push_back(w);
        eng_rx_put = 1'b1; eng_rx_word = w;
        @(negedge clk);
        eng_rx_put = 1'b0; #1;
    endtask

    task automatic rx_read();
        @(negedge clk);
        if (rx_level == '0) rx_q.push_back('0);
        bus_rx_rd = 1'b1;
        @(negedge clk);
        bus_rx_rd = 1'b0; #1;
    endtask

    // which: 0 tx thr, 1 rx thr, 2 tx wm, 3 rx wm, 4 mask, 5 clear, 6 dma enable
    task automatic cfg_write(input int which, input logic [7:0] v);
        @(negedge clk);
        cfg_wdata = v; mask_wdata = v[4:0]; clr_wdata = v[3:0]; dma_en_wdata = v[1:0];
        case (which)
            0: tx_thr_we = 1'b1;
            1: rx_thr_we = 1'b1;
            2: tx_wm_we = 1'b1;
            3: rx_wm_we = 1'b1;
            4: mask_we = 1'b1;
            5: clr_we = 1'b1;
            default: dma_en_we = 1'b1;
        endcase
        @(negedge clk);
        {tx_thr_we, rx_thr_we, tx_wm_we, rx_wm_we, mask_we, clr_we, dma_en_we} = '0; #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1; #1;
        // R1 reset state
        chk("R1 tx_level", 32'(tx_level), 0);
        chk("R1 rx_level", 32'(rx_level), 0);
        chk("R1 status", 32'(status), 32'b01100);
        chk("R1 raw", 32'(raw_irq), 32'b00001);
        chk("R1 irq", {29'b0, irq, tx_dma_req, rx_dma_req}, 0);

        // R2 / R10 basic transmit path
        for (int i = 0; i < 3; i++) tx_write(16'hA100 + 16'(i));
        chk("R2 tx level", 32'(tx_level), 3);
        chk("R10 status busy", 32'(status), 32'b01001);
        chk("R7 tx not low", 32'(raw_irq[0]), 0);
        tx_drain(3);
        chk("R2 tx level drained", 32'(tx_level), 0);

        // R10 busy from engine alone
        eng_busy = 1'b1; #1;
        chk("R10 engine busy", 32'(status), 32'b01101);
        eng_busy = 1'b0;

        // R3 transmit overflow
        for (int i = 0; i < DEPTH; i++) tx_write(16'hB200 + 16'(i));
        chk("R10 tx full", 32'(status[1]), 1);
        tx_write(16'hBEEF);
        chk("R3 level held", 32'(tx_level), DEPTH);
        chk("R3 overflow flag", 32'(raw_irq[1]), 1);
        tx_drain(DEPTH);
        chk("R6 sticky after drain", 32'(raw_irq[1]), 1);
        cfg_write(5, 8'b0010);
        chk("R6 other clear ignored", 32'(raw_irq[1]), 1);
        cfg_write(5, 8'b1000);
        chk("R6 tx overflow cleared", 32'(raw_irq[1]), 0);

        // R4 receive path and underflow
        rx_put(16'hC001); rx_put(16'hC002);
        chk("R2 rx level", 32'(rx_level), 2);
        chk("R10 rx not empty", 32'(status[3]), 0);
        rx_read(); rx_read();
        rx_read();
        chk("R4 underflow flag", 32'(raw_irq[2]), 1);

        // R5 receive overflow
        for (int i = 0; i < DEPTH; i++) rx_put(16'hD300 + 16'(i));
        chk("R10 rx full", 32'(status[4]), 1);
        rx_put(16'hDEAD);
        chk("R5 level held", 32'(rx_level), DEPTH);
        chk("R5 overflow flag", 32'(raw_irq[3]), 1);

        // R7 receive threshold
        cfg_write(1, 8'd3);
        chk("R8 rx thr stored", 32'(rx_thr), 3);
        chk("R7 rx high", 32'(raw_irq[4]), 1);
        for (int i = 0; i < 5; i++) rx_read();
        chk("R7 rx at threshold", 32'(raw_irq[4]), 0);
        for (int i = 0; i < 3; i++) rx_read();

        // R6 selective and full clears
        chk("R6 rx flags set", 32'(raw_irq[3:2]), 2'b11);
        cfg_write(5, 8'b0100);
        chk("R6 rx ovf only", 32'(raw_irq[3:2]), 2'b01);
        for (int i = 0; i <= DEPTH; i++) tx_write(16'hE000 + 16'(i));
        chk("R3 overflow again", 32'(raw_irq[1]), 1);
        cfg_write(5, 8'b0001);
        chk("R6 clear all", 32'(raw_irq[3:1]), 0);
        tx_drain(DEPTH);

        // R8 threshold clamping
        cfg_write(0, 8'd5);
        chk("R8 tx thr 5", 32'(tx_thr), 5);
        cfg_write(0, 8'(DEPTH));
        chk("R8 depth rejected", 32'(tx_thr), 5);
        cfg_write(0, 8'd200);
        chk("R8 large rejected", 32'(tx_thr), 5);
        cfg_write(0, 8'(DEPTH - 1));
        chk("R8 max accepted", 32'(tx_thr), DEPTH - 1);
        cfg_write(1, 8'd9);
        chk("R8 rx rejected", 32'(rx_thr), 3);

        // R7 transmit threshold
        cfg_write(0, 8'd2);
        for (int i = 0; i < 3; i++) tx_write(16'hF000 + 16'(i));
        chk("R7 tx above thr", 32'(raw_irq[0]), 0);
        tx_drain(1);
        chk("R7 tx at thr", 32'(raw_irq[0]), 1);
        tx_drain(2);

        // R9 masking
        for (int i = 0; i <= DEPTH; i++) tx_write(16'h1200 + 16'(i));
        cfg_write(4, 8'b00010);
        chk("R9 masked", 32'(masked_irq), 32'b00010);
        chk("R9 irq high", 32'(irq), 1);
        cfg_write(4, 8'b00100);
        chk("R9 masked off", 32'(masked_irq), 0);
        chk("R9 irq low", 32'(irq), 0);

        // R12 set wins over clear in the same cycle
        cfg_write(5, 8'b1000);
        @(negedge clk);
        bus_tx_wr = 1'b1; bus_tx_wdata = 16'h7777;
        clr_we = 1'b1; clr_wdata = 4'b1000;
        @(negedge clk);
        bus_tx_wr = 1'b0; clr_we = 1'b0; #1;
        chk("R12 set wins", 32'(raw_irq[1]), 1);
        cfg_write(5, 8'b0001);
        tx_drain(DEPTH);

        // R11 DMA requests
        chk("R11 disabled", {30'b0, tx_dma_req, rx_dma_req}, 0);
        cfg_write(6, 8'b10);
        chk("R11 tx req at 0", {30'b0, tx_dma_req, rx_dma_req}, 32'b10);
        cfg_write(2, 8'd2);
        tx_write(16'h0001); tx_write(16'h0002);
        chk("R11 tx req at wm", 32'(tx_dma_req), 1);
        tx_write(16'h0003);
        chk("R11 tx above wm", 32'(tx_dma_req), 0);
        tx_drain(3);
        cfg_write(3, 8'd1);
        cfg_write(6, 8'b11);
        rx_put(16'h0A0A);
        chk("R11 rx at wm", 32'(rx_dma_req), 0);
        rx_put(16'h0B0B);
        chk("R11 rx above wm", 32'(rx_dma_req), 1);
        cfg_write(6, 8'b10);
        chk("R11 rx disabled", 32'(rx_dma_req), 0);
        rx_read(); rx_read();

        chk("R2 queues drained", tx_q.size() + rx_q.size(), 0);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule